// File: doc/BRIEF.md
# Multi-Source Host Byte Read Port

This block sits between a host and the page buffer of a flash controller. It hands the host one byte per read strobe, and the last flash command decides where that byte comes from. Data reads take bytes from the page buffer. ID reads pick byte lanes out of two captured ID words. Status reads always return the captured status byte. Parameter-page reads take bytes from the page buffer with the byte order inside each 32-bit word reversed, because the buffer stores words big-endian.

A running offset moves forward by one on every byte read in every mode. Each new command reloads it. The host can also ask for a block read of several bytes, which the port serves only while it is in data mode. Host writes into the page buffer are limited to the page-plus-spare size. The number of bytes actually stored is added to a write-size total, which the command sequencer reads as the transfer length and clears when a command completes.

Top module: `flash_byte_port`

## Requirements
- R1: After a sampled `rd_stb`, `rd_valid` is high with the byte on `rd_data` in the next cycle. In data mode the byte is the buffer byte at the running offset. An offset at or beyond page-plus-spare returns 0xFF.
- R2: The running offset grows by one for every byte read, whatever the mode.
- R3: `cmd_valid` with `cmd_op` sets the source mode. Op 2 (ID read) selects ID, op 3 selects status, op 4 selects parameter page. Op 0 (data read), op 1 (program setup) and every other op value select data.
- R4: A command loads the offset from `cmd_col`, or 0 when `cmd_col` is negative. Op 1 and op 2 always load 0.
- R5: In ID mode, offsets 0, 1, 2 and 3 return bits 31:24, 23:16, 15:8 and 7:0 of `id_word0`. Any offset of 4 or more returns `id_word1_msb`.
- R6: In status mode every read returns `status_byte`, at any offset.
- R7: In parameter-page mode the buffer address is the offset XOR 3.
- R8: In data mode, a `blk_start` with length L streams L bytes, one per cycle, starting one cycle after the start. Outside data mode `blk_start` has no effect: it produces no `rd_valid` and leaves the offset unchanged.
- R9: `wr_start` with length L grants G = min(L, page+spare − offset), or 0 when the offset is already at or beyond the limit. The next G `wr_byte_stb` bytes are stored from the old offset upward, and any further bytes are dropped.
- R10: On `wr_start`, both the offset and `wr_total` grow by G.
- R11: `cmd_done` clears `wr_total` in the next cycle.
- R12: After reset, `rd_valid` is 0, `wr_total` is 0 and the mode is data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | New command issued this cycle |
| cmd_op | input | 3 | Command kind (encoding in R3) |
| cmd_col | input | OFS_W+1 | Signed column of the command |
| cmd_done | input | 1 | Command completed pulse |
| id_word0 | input | 32 | First captured ID word |
| id_word1_msb | input | 8 | Top byte of the second captured ID word |
| status_byte | input | 8 | Low byte of the captured status word |
| rd_stb | input | 1 | Single byte read strobe |
| blk_start | input | 1 | Start a block read |
| blk_len | input | OFS_W | Block read length in bytes |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| wr_start | input | 1 | Start a buffer write |
| wr_len | input | OFS_W | Requested write length |
| wr_byte_stb | input | 1 | Write byte strobe |
| wr_byte | input | 8 | Write byte |
| wr_total | output | OFS_W+1 | Accumulated stored byte count |

## Verification
Every read result arrives exactly one cycle after its strobe is sampled, because the buffer read and the register-lane capture share one pipeline stage. The bench therefore drives a strobe at a falling edge and checks `rd_valid` and `rd_data` at the next falling edge. A block read returns its first byte one cycle after the cycle in which `blk_start` is sampled, and the bench checks one byte per following falling edge, then one more cycle to confirm the stream has stopped. Changes to `wr_total` from `wr_start` and from `cmd_done` are due one edge after the pulse and are checked at the falling edge that follows. Offset effects are checked through the next read.

// File: rtl/fbp_pkg.sv
// Shared types for the multi-source byte read port.
// Assumes: command kinds arrive as a 3-bit code on the top's ports.
package fbp_pkg;

    typedef enum logic [1:0] {
        SRC_DATA  = 2'd0,
        SRC_ID    = 2'd1,
        SRC_STAT  = 2'd2,
        SRC_PARAM = 2'd3
    } src_mode_e;

    typedef enum logic [2:0] {
        OP_READ       = 3'd0,
        OP_PROG_SETUP = 3'd1,
        OP_READ_ID    = 3'd2,
        OP_STATUS     = 3'd3,
        OP_PARAM      = 3'd4
    } flash_op_e;

endpackage

// File: rtl/fbp_clamp.sv
// Write-length clamp: grants the smaller of the requested length and the
// room left between the offset and the end of page-plus-spare.
// Assumes: DEPTH fits in OFS_W bits.
module fbp_clamp #(
    parameter int OFS_W = 16,
    parameter int DEPTH = 2304
) (
    input  logic [OFS_W-1:0] offset,
    input  logic [OFS_W-1:0] req_len,
    output logic [OFS_W-1:0] grant
);
    localparam logic [OFS_W-1:0] LIMIT = OFS_W'(DEPTH);

    logic [OFS_W-1:0] room;

    // Room left in the buffer, then the granted count.
    always_comb begin
        room  = (offset >= LIMIT) ? '0 : (LIMIT - offset);
        grant = (req_len < room) ? req_len : room;
    end
endmodule

// File: rtl/fbp_steer.sv
// Byte-lane steering: from the mode and the offset, picks either a buffer
// address or a byte taken from the captured ID or status registers.
// Assumes: ID words are stored most significant byte first.
module fbp_steer
    import fbp_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  src_mode_e        mode,
    input  logic [OFS_W-1:0] offset,
    input  logic [31:0]      id_word0,
    input  logic [7:0]       id_word1_msb,
    input  logic [7:0]       status_byte,
    output logic [OFS_W-1:0] ram_addr,
    output logic             use_ram,
    output logic [7:0]       reg_byte
);
    localparam logic [OFS_W-1:0] ID_SPAN  = OFS_W'(4);
    localparam logic [OFS_W-1:0] LANE_FLP = OFS_W'(3);

    // Select the source and the byte lane for the current mode.
    always_comb begin
        ram_addr = offset;
        use_ram  = 1'b1;
        reg_byte = 8'h00;
        unique case (mode)
            SRC_ID: begin
                use_ram = 1'b0;
                if (offset < ID_SPAN)
                    reg_byte = id_word0[{~offset[1:0], 3'b000} +: 8];
                else
                    reg_byte = id_word1_msb;
            end
            SRC_STAT: begin
                use_ram  = 1'b0;
                reg_byte = status_byte;
            end
            SRC_PARAM: ram_addr = offset ^ LANE_FLP;
            default:   ram_addr = offset;
        endcase
    end
endmodule

// File: rtl/fbp_ram.sv
// Page buffer: one synchronous write port and one synchronous read port
// with one cycle of read latency. Reads out of range return 0xFF, and
// writes out of range are dropped.
// Assumes: DEPTH fits in OFS_W bits.
module fbp_ram #(
    parameter int OFS_W = 16,
    parameter int DEPTH = 2304
) (
    input  logic             clk,
    input  logic             we,
    input  logic [OFS_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic             re,
    input  logic [OFS_W-1:0] raddr,
    output logic [7:0]       rdata
);
    localparam int               AW    = $clog2(DEPTH);
    localparam logic [OFS_W-1:0] LIMIT = OFS_W'(DEPTH);

    logic [7:0] mem [DEPTH];

    // Store a write byte that falls inside the buffer.
    always_ff @(posedge clk) begin
        if (we && (waddr < LIMIT))
            mem[waddr[AW-1:0]] <= wdata;
    end

    // Registered read, with 0xFF beyond the end of the buffer.
    always_ff @(posedge clk) begin
        if (re)
            rdata <= (raddr < LIMIT) ? mem[raddr[AW-1:0]] : 8'hFF;
    end
endmodule

// File: rtl/fbp_ctrl.sv
// Port control: source mode register, running offset, block-read counter,
// write pointer and accumulated write size.
// Assumes: on the offset, a command takes priority over a write start,
// and a write start takes priority over a read.
module fbp_ctrl
    import fbp_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int DEPTH = 2304
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [OFS_W:0]   cmd_col,
    input  logic             cmd_done,
    input  logic             rd_stb,
    input  logic             blk_start,
    input  logic [OFS_W-1:0] blk_len,
    input  logic             wr_start,
    input  logic [OFS_W-1:0] wr_len,
    input  logic             wr_byte_stb,
    output src_mode_e        mode,
    output logic [OFS_W-1:0] offset,
    output logic             busy,
    output logic             rd_fire,
    output logic             wr_en,
    output logic [OFS_W-1:0] wr_addr,
    output logic [OFS_W:0]   wr_total
);
    logic [OFS_W-1:0] blk_left;
    logic [OFS_W-1:0] wr_left;
    logic [OFS_W-1:0] grant;
    logic             wr_take;

    fbp_clamp #(.OFS_W(OFS_W), .DEPTH(DEPTH)) u_clamp (
        .offset  (offset),
        .req_len (wr_len),
        .grant   (grant)
    );

    // Read and write strobes seen by the buffer.
    always_comb begin
        busy    = (blk_left != '0);
        rd_fire = busy || rd_stb;
        wr_take = wr_start && !cmd_valid;
        wr_en   = wr_byte_stb && (wr_left != '0);
    end

    // Source mode follows the last command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= SRC_DATA;
        else if (cmd_valid)
            case (cmd_op)
                OP_READ_ID: mode <= SRC_ID;
                OP_STATUS:  mode <= SRC_STAT;
                OP_PARAM:   mode <= SRC_PARAM;
                default:    mode <= SRC_DATA;
            endcase
    end

    // Running offset: load on a command, skip on a write, step on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            offset <= '0;
        else if (cmd_valid) begin
            if (cmd_op == OP_PROG_SETUP || cmd_op == OP_READ_ID || cmd_col[OFS_W])
                offset <= '0;
            else
                offset <= cmd_col[OFS_W-1:0];
        end
        else if (wr_take)
            offset <= offset + grant;
        else if (rd_fire)
            offset <= offset + 1'b1;
    end

    // Block-read byte counter, armed only in data mode.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_valid)
            blk_left <= '0;
        else if (busy)
            blk_left <= blk_left - 1'b1;
        else if (blk_start && mode == SRC_DATA)
            blk_left <= blk_len;
    end

    // Write pointer and the bytes still granted to the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_left <= '0;
        end
        else if (wr_take) begin
            wr_addr <= offset;
            wr_left <= grant;
        end
        else if (wr_en) begin
            wr_addr <= wr_addr + 1'b1;
            wr_left <= wr_left - 1'b1;
        end
    end

    // Accumulated stored size, cleared when a command completes.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_done)
            wr_total <= '0;
        else if (wr_take)
            wr_total <= wr_total + {1'b0, grant};
    end
endmodule

// File: rtl/flash_byte_port.sv
// Multi-source host byte read port. It returns one byte per strobe from
// the page buffer, the ID words or the status byte, as the last command
// selected, and clamps host writes into the buffer.
// Assumes: the host does not raise rd_stb while a block read is streaming.
module flash_byte_port
    import fbp_pkg::*;
#(
    parameter int PAGE_BYTES  = 2048,
    parameter int SPARE_BYTES = 256,
    parameter int OFS_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [OFS_W:0]   cmd_col,
    input  logic             cmd_done,
    input  logic [31:0]      id_word0,
    input  logic [7:0]       id_word1_msb,
    input  logic [7:0]       status_byte,
    input  logic             rd_stb,
    input  logic             blk_start,
    input  logic [OFS_W-1:0] blk_len,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    input  logic             wr_start,
    input  logic [OFS_W-1:0] wr_len,
    input  logic             wr_byte_stb,
    input  logic [7:0]       wr_byte,
    output logic [OFS_W:0]   wr_total
);
    localparam int DEPTH = PAGE_BYTES + SPARE_BYTES;

    src_mode_e        mode_w;
    logic [OFS_W-1:0] ofs_w;
    logic             busy_w;
    logic             fire_w;
    logic             wen_w;
    logic [OFS_W-1:0] waddr_w;
    logic [OFS_W-1:0] raddr_w;
    logic             use_ram_w;
    logic [7:0]       reg_byte_w;
    logic [7:0]       ram_q;
    logic             sel_ram_q;
    logic [7:0]       reg_byte_q;

    fbp_ctrl #(.OFS_W(OFS_W), .DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_col     (cmd_col),
        .cmd_done    (cmd_done),
        .rd_stb      (rd_stb),
        .blk_start   (blk_start),
        .blk_len     (blk_len),
        .wr_start    (wr_start),
        .wr_len      (wr_len),
        .wr_byte_stb (wr_byte_stb),
        .mode        (mode_w),
        .offset      (ofs_w),
        .busy        (busy_w),
        .rd_fire     (fire_w),
        .wr_en       (wen_w),
        .wr_addr     (waddr_w),
        .wr_total    (wr_total)
    );

    fbp_steer #(.OFS_W(OFS_W)) u_steer (
        .mode         (mode_w),
        .offset       (ofs_w),
        .id_word0     (id_word0),
        .id_word1_msb (id_word1_msb),
        .status_byte  (status_byte),
        .ram_addr     (raddr_w),
        .use_ram      (use_ram_w),
        .reg_byte     (reg_byte_w)
    );

    fbp_ram #(.OFS_W(OFS_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (wen_w),
        .waddr (waddr_w),
        .wdata (wr_byte),
        .re    (fire_w),
        .raddr (raddr_w),
        .rdata (ram_q)
    );

    // Output stage, aligned with the buffer's read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            sel_ram_q  <= 1'b1;
            reg_byte_q <= 8'h00;
        end
        else begin
            rd_valid <= fire_w;
            if (fire_w) begin
                sel_ram_q  <= use_ram_w;
                reg_byte_q <= reg_byte_w;
            end
        end
    end

    // Return the buffer byte or the captured register byte.
    always_comb rd_data = sel_ram_q ? ram_q : reg_byte_q;
endmodule

// File: rtl/fbp_checker.sv
// Protocol checker for flash_byte_port. It is bound to the top and reads
// its ports and its control state.
// Assumes: the same parameters as the top it is bound to.
module fbp_checker
    import fbp_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_stb,
    input logic             rd_valid,
    input logic [7:0]       rd_data,
    input logic             cmd_valid,
    input logic             cmd_done,
    input logic             wr_start,
    input logic [OFS_W-1:0] wr_len,
    input logic [OFS_W:0]   wr_total,
    input logic             blk_start,
    input src_mode_e        mode,
    input logic [OFS_W-1:0] offset,
    input logic             busy,
    input logic [7:0]       status_byte,
    input logic [7:0]       id_word1_msb
);
    localparam int TOT_W = OFS_W + 1;

    a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);

    a_r2_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !busy && !cmd_valid && !wr_start) |=> offset == $past(offset) + 1'b1);

    a_r5_id_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode == SRC_ID && offset >= OFS_W'(4)) |=> rd_data == $past(id_word1_msb));

    a_r6_status_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode == SRC_STAT) |=> rd_data == $past(status_byte));

    a_r8_block_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_start && mode != SRC_DATA && !busy && !cmd_valid) |=> !busy);

    a_r10_grant_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && !cmd_valid && !cmd_done) |=>
            (wr_total - $past(wr_total)) <= TOT_W'($past(wr_len)));

    a_r11_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> wr_total == '0);
endmodule

bind flash_byte_port fbp_checker #(.OFS_W(OFS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_stb       (rd_stb),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .cmd_valid    (cmd_valid),
    .cmd_done     (cmd_done),
    .wr_start     (wr_start),
    .wr_len       (wr_len),
    .wr_total     (wr_total),
    .blk_start    (blk_start),
    .mode         (mode_w),
    .offset       (ofs_w),
    .busy         (busy_w),
    .status_byte  (status_byte),
    .id_word1_msb (id_word1_msb)
);

// File: tb/tb_flash_byte_port.sv
// Bench for flash_byte_port on a small buffer (32 + 8 bytes). Inputs are
// driven at falling edges and outputs are sampled at falling edges.
module tb_flash_byte_port;
    localparam int PAGE  = 32;
    localparam int SPARE = 8;
    localparam int OW    = 8;
    localparam int DEP   = PAGE + SPARE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [OW:0]   cmd_col = '0;
    logic          cmd_done = 1'b0;
    logic [31:0]   id_word0 = '0;
    logic [7:0]    id_word1_msb = '0;
    logic [7:0]    status_byte = '0;
    logic          rd_stb = 1'b0;
    logic          blk_start = 1'b0;
    logic [OW-1:0] blk_len = '0;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic          wr_start = 1'b0;
    logic [OW-1:0] wr_len = '0;
    logic          wr_byte_stb = 1'b0;
    logic [7:0]    wr_byte = '0;
    logic [OW:0]   wr_total;

    int   n_chk  = 0;
    int   n_fail = 0;
    logic [7:0] em [DEP];

    always #2 clk = ~clk;

    flash_byte_port #(.PAGE_BYTES(PAGE), .SPARE_BYTES(SPARE), .OFS_W(OW)) dut (
        .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_col, .cmd_done,
        .id_word0, .id_word1_msb, .status_byte, .rd_stb, .blk_start, .blk_len,
        .rd_valid, .rd_data, .wr_start, .wr_len, .wr_byte_stb, .wr_byte, .wr_total
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_cmd(input int op, input int col);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_col   = (OW+1)'(col);
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic chk_rd(input int exp, input string tag);
        rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
        chk({23'd0, rd_valid, rd_data}, 256 + exp, tag);
    endtask

    task automatic wr_req(input int len);
        wr_start = 1'b1;
        wr_len   = OW'(len);
        tick();
        wr_start = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int vcount;
        @(negedge clk);
        repeat (3) tick();
        chk(rd_valid, 0, "R12 reset valid");
        chk(int'(wr_total), 0, "R12 reset total");
        rst_n = 1'b1;
        tick();

        // R4: program setup forces the offset to 0; R9 clamps to 40
        do_cmd(1, 5);
        wr_req(50);
        chk(int'(wr_total), 40, "R10 total after clamp");
        for (int i = 0; i < 45; i++) begin
            wr_byte_stb = 1'b1;
            wr_byte     = 8'((i * 7 + 3) & 255);
            if (i < DEP) em[i] = wr_byte;
            tick();
        end
        wr_byte_stb = 1'b0;
        wr_req(3);
        chk(int'(wr_total), 40, "R9 zero grant at limit");
        cmd_done = 1'b1;
        tick();
        cmd_done = 1'b0;
        chk(int'(wr_total), 0, "R11 done clears");

        // R1/R2: full data sweep, which also shows that bytes 40..44 were dropped
        do_cmd(0, 0);
        for (int i = 0; i < DEP; i++) chk_rd(em[i], "R1 data sweep");
        chk_rd(8'hFF, "R1 beyond limit");

        do_cmd(0, -3);
        chk_rd(em[0], "R4 negative column");
        chk_rd(em[1], "R2 step");
        do_cmd(0, 17);
        chk_rd(em[17], "R4 column load");

        // R7: parameter page with lane reversal
        do_cmd(4, 0);
        for (int i = 0; i < DEP; i++) chk_rd(em[i ^ 3], "R7 param lanes");

        // R5: ID lanes; R8: block read ignored in ID mode
        id_word0     = 32'hA1B2C3D4;
        id_word1_msb = 8'h5E;
        do_cmd(2, 9);
        chk_rd(8'hA1, "R5 id byte0");
        chk_rd(8'hB2, "R5 id byte1");
        blk_start = 1'b1;
        blk_len   = 8'd4;
        tick();
        blk_start = 1'b0;
        vcount = 0;
        for (int i = 0; i < 6; i++) begin
            tick();
            vcount += int'(rd_valid);
        end
        chk(vcount, 0, "R8 block ignored no valid");
        chk_rd(8'hC3, "R8 offset unchanged by block");
        chk_rd(8'hD4, "R5 id byte3");
        chk_rd(8'h5E, "R5 id index4");
        chk_rd(8'h5E, "R5 id index5");
        chk_rd(8'h5E, "R2 id index6");

        // R6: status at any offset
        status_byte = 8'hE0;
        do_cmd(3, 6);
        for (int i = 0; i < 5; i++) chk_rd(8'hE0, "R6 status");

        // R3: another op value returns to data mode
        do_cmd(5, 2);
        chk_rd(em[2], "R3 back to data");

        // R8: block read in data mode
        do_cmd(0, 10);
        blk_start = 1'b1;
        blk_len   = 8'd5;
        tick();
        blk_start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk({23'd0, rd_valid, rd_data}, 256 + int'(em[10 + i]), "R8 block byte");
        end
        tick();
        chk(rd_valid, 0, "R8 block ends");
        chk_rd(em[15], "R8 offset after block");

        // R9/R10: partial grant near the end
        do_cmd(0, 37);
        wr_req(10);
        chk(int'(wr_total), 3, "R10 partial grant total");
        for (int i = 0; i < 5; i++) begin
            wr_byte_stb = 1'b1;
            wr_byte     = 8'(8'hF0 + i);
            if (37 + i < DEP) em[37 + i] = wr_byte;
            tick();
        end
        wr_byte_stb = 1'b0;
        chk_rd(8'hFF, "R10 offset advanced by grant");
        do_cmd(0, 36);
        for (int i = 36; i < DEP; i++) chk_rd(em[i], "R9 partial store");

        finish_run();
    end
endmodule